// File: doc/BRIEF.md
# Completion interrupt coalescer with idle-packet delay timer

This block decides when one DMA channel raises its completion and delay interrupts. Each per-packet completion event decrements a down-counter that is loaded from a programmable threshold. When the last event of a batch arrives, the block emits a one-cycle completion set pulse and reloads the counter. A batch can also be left unfinished. In that case an idle timer flushes it: the timer starts at the end of a packet, is prescaled by 125, and expires after 125 × delay clock cycles. On expiry the block emits a delay set pulse and starts a fresh batch.

The pulses drive the set inputs of status flags that live elsewhere. The block also presents the current batch count and the elapsed delay ticks so they can be read back as status. A threshold of zero is never accepted. A delay of zero turns the timer off.

Top module: `irq_coalesce`

## Requirements
- R1: After reset the threshold is 1 and `thr_live` reads 1. A threshold write with value 0 is ignored and leaves `thr_live` unchanged. A non-zero write makes `thr_live` equal the new value one cycle later.
- R2: Each `cmpl_evt` decrements `thr_live`. The event that finds `thr_live` at 1 makes `cmpl_set` high for exactly the next cycle and reloads `thr_live` to the programmed threshold.
- R3: With `cmpl_irq_en` low, `cmpl_set` stays low, but counting and reloading are unchanged.
- R4: Once completion events are pending and `pkt_end` has been seen, `dly_set` pulses in the cycle that follows the 125×D-th rising edge after the `pkt_end` edge, where D is the non-zero delay value. `thr_live` then reloads to the threshold, and `dly_live` shows the completed groups of 125 cycles.
- R5: A delay value of 0 never produces `dly_set`. With `dly_irq_en` low, expiry produces no pulse but still reloads `thr_live`.
- R6: `pkt_start` stops the timer and clears `dly_live`. No expiry follows until the next `pkt_end`, which restarts the full window.
- R7: A batch that completes by count clears the pending state, so no delay expiry follows it.
- R8: After reset `cmpl_set`, `dly_set` and `dly_live` are 0.
- R9: An expiry that coincides with `cmpl_evt`, `pkt_start` or a register write is dropped and the window restarts from zero. `cmpl_set` and `dly_set` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmpl_evt | input | 1 | Completion event strobe |
| pkt_start | input | 1 | Start-of-packet strobe |
| pkt_end | input | 1 | End-of-packet strobe |
| thr_wr | input | 1 | Threshold field write strobe |
| thr_val | input | 8 | Threshold write value |
| dly_wr | input | 1 | Delay field write strobe |
| dly_val | input | 8 | Delay write value |
| cmpl_irq_en | input | 1 | Completion interrupt enable |
| dly_irq_en | input | 1 | Delay interrupt enable |
| cmpl_set | output | 1 | Set pulse for the completion flag |
| dly_set | output | 1 | Set pulse for the delay flag |
| thr_live | output | 8 | Current batch count |
| dly_live | output | 8 | Elapsed delay ticks |

## Verification
Thresholds 1 through 6 are each swept over two full batches. Checking the pulse position and the live count after every event separates an off-by-one in the reload from a missing reload. Delays 1 to 3 are timed to the exact cycle, with a check one cycle before the expected pulse and one on it. This separates a wrong prescale from a wrong tick comparison. The zero-delay case, the disabled enable, a packet start in mid-window, a batch that completes by count, and an event that collides with expiry each isolate one of the suppression or restart rules.

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
  parameter int          W        = 8,
  parameter int          PRESCALE = 125,
  parameter logic [W-1:0] THR_INIT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmpl_evt,
  input  logic         pkt_start,
  input  logic         pkt_end,
  input  logic         thr_wr,
  input  logic [W-1:0] thr_val,
  input  logic         dly_wr,
  input  logic [W-1:0] dly_val,
  input  logic         cmpl_irq_en,
  input  logic         dly_irq_en,
  output logic         cmpl_set,
  output logic         dly_set,
  output logic [W-1:0] thr_live,
  output logic [W-1:0] dly_live
);
  localparam int PW = $clog2(PRESCALE);

  logic [W-1:0]  thr_cfg, thr_cnt, dly_cfg, tick;
  logic [PW-1:0] pre;
  logic          running, pending;

  wire thr_load   = thr_wr && (thr_val != '0);
  wire fire       = cmpl_evt && !thr_load && (thr_cnt == W'(1));
  wire counting   = running && pending && (dly_cfg != '0);
  wire pre_wrap   = (pre == PW'(PRESCALE - 1));
  wire expire_raw = counting && pre_wrap && (tick == dly_cfg - 1'b1);
  wire expire     = expire_raw && !cmpl_evt && !pkt_start && !thr_wr && !dly_wr;
  wire restart    = pkt_end || pkt_start || dly_wr || thr_load || fire || expire_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr_cfg <= THR_INIT;
      thr_cnt <= THR_INIT;
    end else if (thr_load) begin
      thr_cfg <= thr_val;
      thr_cnt <= thr_val;
    end else if (cmpl_evt) begin
      thr_cnt <= fire ? thr_cfg : thr_cnt - 1'b1;
    end else if (expire) begin
      thr_cnt <= thr_cfg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dly_cfg <= '0;
    else if (dly_wr) dly_cfg <= dly_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            pending <= 1'b0;
    else if (thr_load || fire || expire)   pending <= 1'b0;
    else if (cmpl_evt)                     pending <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    running <= 1'b0;
    else if (pkt_end)              running <= 1'b1;
    else if (pkt_start || expire)  running <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre  <= '0;
      tick <= '0;
    end else if (counting) begin
      if (pre_wrap) begin
        pre  <= '0;
        tick <= tick + 1'b1;
      end else begin
        pre  <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpl_set <= 1'b0;
      dly_set  <= 1'b0;
    end else begin
      cmpl_set <= fire && cmpl_irq_en;
      dly_set  <= expire && dly_irq_en;
    end
  end

  assign thr_live = thr_cnt;
  assign dly_live = tick;
endmodule

// File: rtl/irq_coalesce_chk.sv
module irq_coalesce_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         cmpl_evt,
  input logic         pkt_start,
  input logic         pkt_end,
  input logic         thr_wr,
  input logic [W-1:0] thr_val,
  input logic         dly_wr,
  input logic         cmpl_irq_en,
  input logic         dly_irq_en,
  input logic         cmpl_set,
  input logic         dly_set,
  input logic [W-1:0] thr_live,
  input logic [W-1:0] dly_live
);
  AST_THR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) thr_live != '0); // R1
  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && thr_val == '0 && !cmpl_evt) |=> $stable(thr_live)); // R1
  AST_CMPL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_set |-> $past(cmpl_evt && cmpl_irq_en)); // R3
  AST_DLY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dly_set |-> $past(dly_irq_en && !pkt_start && !cmpl_evt && !thr_wr && !dly_wr)); // R5
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !pkt_end) |=> dly_live == '0); // R6
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmpl_set && dly_set)); // R9
endmodule

bind irq_coalesce irq_coalesce_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmpl_evt(cmpl_evt), .pkt_start(pkt_start),
  .pkt_end(pkt_end), .thr_wr(thr_wr), .thr_val(thr_val), .dly_wr(dly_wr),
  .cmpl_irq_en(cmpl_irq_en), .dly_irq_en(dly_irq_en), .cmpl_set(cmpl_set),
  .dly_set(dly_set), .thr_live(thr_live), .dly_live(dly_live)
);

// File: tb/sim_irq_coalesce.sv
module sim_irq_coalesce;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmpl_evt = 0, pkt_start = 0, pkt_end = 0, thr_wr = 0, dly_wr = 0;
  logic [7:0] thr_val = 0, dly_val = 0;
  logic cmpl_irq_en = 1, dly_irq_en = 1;
  logic cmpl_set, dly_set;
  logic [7:0] thr_live, dly_live;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_coalesce u0 (.*);

  task automatic step();
    @(posedge clk); #1;
    cmpl_evt = 0; pkt_start = 0; pkt_end = 0; thr_wr = 0; dly_wr = 0;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_thr(int v); thr_wr = 1; thr_val = 8'(v); step(); endtask
  task automatic set_dly(int v); dly_wr = 1; dly_val = 8'(v); step(); endtask
  task automatic evt_end(); cmpl_evt = 1; pkt_end = 1; step(); endtask

  task automatic wait_quiet(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin step(); if (dly_set) seen++; end
    check(req, seen, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    step(); step();
    rst_n = 1;
    check("R8 reset cmpl_set", cmpl_set, 0);
    check("R8 reset dly_set", dly_set, 0);
    check("R8 reset dly_live", dly_live, 0);
    check("R1 reset thr_live", thr_live, 1);

    // R2 sweep: thresholds 1..6, two batches each
    for (int t = 1; t <= 6; t++) begin
      set_thr(t);
      check("R1 write reload", thr_live, t);
      for (int k = 1; k <= 2 * t; k++) begin
        cmpl_evt = 1; step();
        check("R2 pulse", cmpl_set, (k % t == 0) ? 1 : 0);
        check("R2 count", thr_live, t - (k % t));
      end
    end

    // R1 zero write ignored mid-count
    set_thr(3);
    cmpl_evt = 1; step();
    set_thr(0);
    check("R1 zero write", thr_live, 2);
    cmpl_evt = 1; step(); cmpl_evt = 1; step();
    check("R1 old threshold kept", cmpl_set, 1);

    // R3 enable off
    cmpl_irq_en = 0;
    set_thr(2);
    cmpl_evt = 1; step(); cmpl_evt = 1; step();
    check("R3 no pulse", cmpl_set, 0);
    check("R3 reload", thr_live, 2);
    cmpl_irq_en = 1;

    // R4 exact timing for D = 1..3
    for (int d = 1; d <= 3; d++) begin
      set_thr(8);
      set_dly(d);
      evt_end();
      for (int i = 1; i < 125 * d; i++) begin
        step();
        if (i == 125 && d > 1) check("R4 dly_live", dly_live, 1);
        if (dly_set) check("R4 early", i, 125 * d);
      end
      check("R4 before expiry", dly_set, 0);
      step();
      check("R4 expiry pulse", dly_set, 1);
      check("R4 reload", thr_live, 8);
    end

    // R5 delay zero
    set_dly(0);
    evt_end();
    wait_quiet(500, "R5 delay zero");
    check("R5 count kept", thr_live, 7);

    // R5 enable off still reloads
    dly_irq_en = 0;
    set_dly(1);
    evt_end();
    check("R5 count", thr_live, 6);
    wait_quiet(300, "R5 enable off");
    check("R5 reload without pulse", thr_live, 8);
    dly_irq_en = 1;

    // R6 packet start stops timer
    evt_end();
    for (int i = 0; i < 100; i++) step();
    pkt_start = 1; step();
    check("R6 dly_live cleared", dly_live, 0);
    wait_quiet(200, "R6 stopped");
    pkt_end = 1; step();
    wait_quiet(124, "R6 restart window");
    step();
    check("R6 expiry after restart", dly_set, 1);

    // R7 batch completes by count
    set_thr(2);
    evt_end();
    for (int i = 0; i < 10; i++) step();
    evt_end();
    check("R7 batch pulse", cmpl_set, 1);
    wait_quiet(300, "R7 no expiry");

    // R9 collision of event with expiry
    set_thr(8);
    evt_end();
    for (int i = 0; i < 124; i++) step();
    cmpl_evt = 1; step();
    check("R9 expiry dropped", dly_set, 0);
    check("R9 count", thr_live, 6);
    wait_quiet(124, "R9 restarted window");
    step();
    check("R9 later expiry", dly_set, 1);
    check("R9 exclusive", cmpl_set, 0);

    finish_run();
  end
endmodule